// File: doc/BRIEF.md
# Bayer Black Level Corrector

This block cleans up raw sensor pixels that arrive one per beat on a valid/ready video stream whose pixels are arranged as a repeating 2x2 mosaic of colour sites. For each pixel it works out which of the four mosaic sites the pixel sits on, removes that site's dark pedestal, and decides what to do with a result that falls below zero. Such a result is either forced to zero or folded back to its magnitude. It then stretches the value back to full scale with a per-site gain and saturates it to the pixel width.

The site of a pixel comes from its row and column parity, counted from the start-of-frame and end-of-line markers, combined with a two-bit mosaic phase. Software changes the phase when the image has been cropped, mirrored or rotated. All parameters arrive through a single-cycle register write port. They land in staging registers and are adopted by the pixel that carries start-of-frame, so every frame is processed with one consistent parameter set. The pixel datapath is a three-register pipeline that stalls as a whole under backpressure.

Top module: `bayer_black_level`

## Requirements
- R1: A pixel's site index is 2*(row ^ phase[1]) + (col ^ phase[0]). The start-of-frame pixel has row 0 and col 0. Col toggles after each accepted pixel and returns to 0 after an accepted end-of-line pixel. Row toggles after each accepted end-of-line pixel.
- R2: Register write addresses: 0 to 3 set the pedestals of sites 0 to 3 (low PIX_W data bits); 4 to 7 set the gains of sites 0 to 3 (16 data bits); 8 sets the phase (data bits 1:0); 9 sets the negative mode (bit 0 = fold enable, bit 1 = force-zero override).
- R3: With fold enable clear, a pixel smaller than its site's pedestal yields zero before the gain stage, and any other pixel yields pixel minus pedestal.
- R4: With fold enable set and force-zero set, a pixel smaller than its pedestal still yields zero.
- R5: With fold enable set and force-zero clear, a pixel smaller than its pedestal yields pedestal minus pixel.
- R6: The gain is unsigned with 12 fractional bits (0x1000 = 1.0). The output is floor((diff*gain + 2048) / 4096), limited to 2^PIX_W - 1.
- R7: A pixel accepted while the output side is never stalled appears on the output in the third cycle after acceptance. After reset, m_valid is 0.
- R8: s_ready equals !m_valid || m_ready. While m_valid is high and m_ready is low, m_data, m_sof and m_eol hold still. Every accepted pixel leaves exactly once, in order, with its own start-of-frame and end-of-line flags.
- R9: Register writes take effect from the next accepted start-of-frame pixel, inclusive, and never inside a frame. Reset values are pedestals 0, gains 0x1000, phase 0 and mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block can accept a pixel |
| s_data | input | PIX_W | Input pixel value |
| s_sof | input | 1 | Input pixel is first of a frame |
| s_eol | input | 1 | Input pixel is last of a line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts the output pixel |
| m_data | output | PIX_W | Corrected pixel value |
| m_sof | output | 1 | Output pixel is first of a frame |
| m_eol | output | 1 | Output pixel is last of a line |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | GAIN_W | Register write data |

## Verification
The bench goes after the mosaic bookkeeping under all four phases. A tracker that failed to clear column parity at line end, or that dropped the phase, would apply the wrong site's pedestal and gain, and outputs would differ by site. It drives pixels below their pedestal in all three negative-handling modes: a wrong mode decode either folds where it should clip or leaks wrapped huge values. It also tests gains that overflow and gains of one half. A missing clamp or a truncating rounder shows up as off-by-one or wrapped results. Random output stalls and mid-frame register writes are used as well: a leaky stall would drop or repeat pixels, and unstaged writes would change the correction partway through a frame.

// File: rtl/blc_pkg.sv
// Shared constants and types for the black level corrector.
// Assumes a 4-bit register address space and a 2x2 mosaic (four sites).
package blc_pkg;
    localparam int NSITE = 4;

    localparam logic [3:0] ADDR_PED0  = 4'd0;
    localparam logic [3:0] ADDR_GAIN0 = 4'd4;
    localparam logic [3:0] ADDR_PHASE = 4'd8;
    localparam logic [3:0] ADDR_MODE  = 4'd9;

    // Negative-result handling: bit 1 forces zero, bit 0 enables folding.
    typedef struct packed {
        logic force_zero;
        logic fold_en;
    } neg_mode_t;
endpackage

// File: rtl/blc_param_bank.sv
// Staged parameter store: writes land in staging registers, and these are
// copied to the active set when a start-of-frame pixel is accepted. The
// start-of-frame pixel itself already sees the staged values.
// Assumes frame_load is a one-cycle pulse coinciding with that acceptance.
module blc_param_bank
    import blc_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int GAIN_W = 16,
    parameter logic [GAIN_W-1:0] GAIN_ONE = 16'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [GAIN_W-1:0] cfg_wdata,
    input  logic              frame_load,
    input  logic [1:0]        site,
    output logic [PIX_W-1:0]  sel_ped,
    output logic [GAIN_W-1:0] sel_gain,
    output logic [1:0]        eff_phase,
    output neg_mode_t         eff_mode
);
    logic [NSITE-1:0][PIX_W-1:0]  stg_ped,  act_ped;
    logic [NSITE-1:0][GAIN_W-1:0] stg_gain, act_gain;
    logic [1:0]                   stg_phase, act_phase;
    neg_mode_t                    stg_mode, act_mode;

    // Capture register writes into staging, and adopt staging at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSITE; i++) begin
                stg_ped[i]  <= '0;
                act_ped[i]  <= '0;
                stg_gain[i] <= GAIN_ONE;
                act_gain[i] <= GAIN_ONE;
            end
            stg_phase <= '0;
            act_phase <= '0;
            stg_mode  <= '0;
            act_mode  <= '0;
        end else begin
            if (cfg_we) begin
                for (int i = 0; i < NSITE; i++) begin
                    if (cfg_addr == ADDR_PED0 + 4'(i))
                        stg_ped[i] <= cfg_wdata[PIX_W-1:0];
                    if (cfg_addr == ADDR_GAIN0 + 4'(i))
                        stg_gain[i] <= cfg_wdata;
                end
                if (cfg_addr == ADDR_PHASE) stg_phase <= cfg_wdata[1:0];
                if (cfg_addr == ADDR_MODE)  stg_mode  <= neg_mode_t'(cfg_wdata[1:0]);
            end
            if (frame_load) begin
                act_ped   <= stg_ped;
                act_gain  <= stg_gain;
                act_phase <= stg_phase;
                act_mode  <= stg_mode;
            end
        end
    end

    // Select the set in force for the current pixel and its site.
    always_comb begin
        eff_phase = frame_load ? stg_phase : act_phase;
        eff_mode  = frame_load ? stg_mode  : act_mode;
        sel_ped   = frame_load ? stg_ped[site]  : act_ped[site];
        sel_gain  = frame_load ? stg_gain[site] : act_gain[site];
    end

    // R9: the active set only changes on an accepted start-of-frame pixel.
    assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> ($stable(act_ped) && $stable(act_gain)
                         && $stable(act_phase) && $stable(act_mode)));
endmodule

// File: rtl/blc_site_tracker.sv
// Tracks row and column parity of the incoming stream and maps them,
// through the mosaic phase, onto a site index 0..3.
// Assumes every frame starts with a pixel flagged sof and lines end with eol.
module blc_site_tracker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       sof,
    input  logic       eol,
    input  logic [1:0] phase,
    output logic [1:0] site
);
    logic row_q, col_q;
    logic row_cur, col_cur;

    // Parity of the pixel now presented; frame start forces row 0, col 0.
    always_comb begin
        row_cur = sof ? 1'b0 : row_q;
        col_cur = sof ? 1'b0 : col_q;
        site    = {row_cur ^ phase[1], col_cur ^ phase[0]};
    end

    // Advance the parities on every accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= 1'b0;
            col_q <= 1'b0;
        end else if (accept) begin
            col_q <= eol ? 1'b0 : ~col_cur;
            row_q <= eol ? ~row_cur : row_cur;
        end
    end

    // R1: after a line ends, the next pixel starts on an even column.
    assert_col_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && eol) |=> !col_q);
endmodule

// File: rtl/blc_datapath.sv
// Three-register pixel pipeline: pedestal removal with clip/fold,
// fixed-point gain with round-half-up, and saturation.
// Assumes all registers advance together on adv; a bubble is a cleared valid.
module blc_datapath
    import blc_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int GAIN_W = 16,
    parameter int FRAC   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [PIX_W-1:0]  ped,
    input  logic [GAIN_W-1:0] gain,
    input  neg_mode_t         mode,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix,
    output logic              out_sof,
    output logic              out_eol
);
    localparam int PW = PIX_W + GAIN_W;
    localparam int RW = PW - FRAC + 1;
    localparam logic [PW:0]      HALF = (PW+1)'(1) << (FRAC - 1);
    localparam logic [PIX_W-1:0] MAXV = '1;

    logic              v1, v2;
    logic              sof1, eol1, sof2, eol2;
    logic [PIX_W-1:0]  mag1;
    logic [GAIN_W-1:0] gain1;
    logic [RW-1:0]     rnd2;

    logic [PIX_W:0]    diff_c;
    logic [PIX_W-1:0]  mag_c;
    logic [PW-1:0]     prod_c;
    logic [PW:0]       sum_c;

    // Stage 1 logic: subtract the pedestal and handle a negative difference.
    always_comb begin
        diff_c = {1'b0, in_pix} - {1'b0, ped};
        if (!diff_c[PIX_W])
            mag_c = diff_c[PIX_W-1:0];
        else if (mode.fold_en && !mode.force_zero)
            mag_c = ped - in_pix;
        else
            mag_c = '0;
    end

    // Stage 2 logic: multiply by the gain and round to nearest.
    always_comb begin
        prod_c = PW'(mag1) * PW'(gain1);
        sum_c  = {1'b0, prod_c} + HALF;
    end

    // Pipeline registers; all stages move together when adv is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            out_valid <= 1'b0;
            mag1      <= '0;
            gain1     <= '0;
            rnd2      <= '0;
            out_pix   <= '0;
            sof1      <= 1'b0;
            eol1      <= 1'b0;
            sof2      <= 1'b0;
            eol2      <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
        end else if (adv) begin
            v1        <= in_valid;
            mag1      <= mag_c;
            gain1     <= gain;
            sof1      <= in_sof;
            eol1      <= in_eol;
            v2        <= v1;
            rnd2      <= sum_c[PW:FRAC];
            sof2      <= sof1;
            eol2      <= eol1;
            out_valid <= v2;
            out_pix   <= (rnd2 > RW'(MAXV)) ? MAXV : rnd2[PIX_W-1:0];
            out_sof   <= sof2;
            out_eol   <= eol2;
        end
    end

    // R8: a held output pixel keeps its value and flags until it advances.
    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !adv) |=> (out_valid && $stable(out_pix)
                                 && $stable(out_sof) && $stable(out_eol)));
endmodule

// File: rtl/bayer_black_level.sv
// Top level of the black level corrector: ties the site tracker, the staged
// parameter bank and the pixel pipeline together under one stall signal.
// Assumes one pixel per beat and frames delimited by sof/eol flags.
module bayer_black_level
    import blc_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int GAIN_W = 16,
    parameter int FRAC   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [PIX_W-1:0]  s_data,
    input  logic              s_sof,
    input  logic              s_eol,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [PIX_W-1:0]  m_data,
    output logic              m_sof,
    output logic              m_eol,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [GAIN_W-1:0] cfg_wdata
);
    localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << FRAC;

    logic              adv, accept, frame_load;
    logic [1:0]        site, phase;
    logic [PIX_W-1:0]  ped;
    logic [GAIN_W-1:0] gain;
    neg_mode_t         mode;

    // Global stall: the pipeline moves whenever its last stage can empty.
    always_comb begin
        adv        = !m_valid || m_ready;
        s_ready    = adv;
        accept     = s_valid && adv;
        frame_load = accept && s_sof;
    end

    blc_site_tracker i_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .sof    (s_sof),
        .eol    (s_eol),
        .phase  (phase),
        .site   (site)
    );

    blc_param_bank #(
        .PIX_W    (PIX_W),
        .GAIN_W   (GAIN_W),
        .GAIN_ONE (GAIN_ONE)
    ) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .frame_load (frame_load),
        .site       (site),
        .sel_ped    (ped),
        .sel_gain   (gain),
        .eff_phase  (phase),
        .eff_mode   (mode)
    );

    blc_datapath #(
        .PIX_W  (PIX_W),
        .GAIN_W (GAIN_W),
        .FRAC   (FRAC)
    ) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .in_valid  (accept),
        .in_pix    (s_data),
        .in_sof    (s_sof),
        .in_eol    (s_eol),
        .ped       (ped),
        .gain      (gain),
        .mode      (mode),
        .out_valid (m_valid),
        .out_pix   (m_data),
        .out_sof   (m_sof),
        .out_eol   (m_eol)
    );

    // Occupancy counter used only to check that no pixel is lost or created.
    logic [2:0] inflight;
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + 3'(accept) - 3'(m_valid && m_ready);
    end

    // R7: never more than three pixels between input and output.
    assert_occupancy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 3'd3);
endmodule

// File: tb/test_bayer_black_level.sv
module test_bayer_black_level;
    localparam int PIX_W  = 12;
    localparam int GAIN_W = 16;
    localparam int MAXV   = (1 << PIX_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [PIX_W-1:0]  s_data = '0;
    logic              s_sof = 1'b0;
    logic              s_eol = 1'b0;
    logic              m_valid;
    logic              m_ready = 1'b1;
    logic [PIX_W-1:0]  m_data;
    logic              m_sof;
    logic              m_eol;
    logic              cfg_we = 1'b0;
    logic [3:0]        cfg_addr = '0;
    logic [GAIN_W-1:0] cfg_wdata = '0;

    always #2 clk = ~clk;

    bayer_black_level #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC(12)) i_bayer_black_level (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof), .s_eol(s_eol),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    string tag = "R9";
    bit steady = 1'b1;
    bit stall_mode = 1'b0;
    int pix_lo = 0;
    int pix_hi = MAXV;

    // Reference model state.
    int stg_ped[4], act_ped[4], stg_gain[4], act_gain[4];
    int stg_ph = 0, act_ph = 0, stg_md = 0, act_md = 0;
    int row = 0, col = 0;

    int    exp_q[$];
    bit    esof_q[$];
    bit    eeol_q[$];
    string tag_q[$];
    int    acyc_q[$];
    bit    lat_q[$];

    bit         hold_prev = 1'b0;
    logic [PIX_W-1:0] hold_data;
    logic       hold_sof, hold_eol;

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int model_pix(int pix, int ped, int gain, int md);
        longint d, r;
        d = pix - ped;
        if (d < 0) begin
            if ((md & 1) != 0 && (md & 2) == 0) d = -d;
            else d = 0;
        end
        r = (d * gain + 2048) >>> 12;
        if (r > MAXV) r = MAXV;
        return int'(r);
    endfunction

    initial begin
        for (int i = 0; i < 4; i++) begin
            stg_ped[i] = 0; act_ped[i] = 0;
            stg_gain[i] = 4096; act_gain[i] = 4096;
        end
    end

    // Output stall pattern, changed away from the active edge.
    always @(negedge clk) m_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;

    // Monitor and reference model, sampled before each rising edge.
    always @(negedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            if (hold_prev)
                chk(m_valid && m_data == hold_data && m_sof == hold_sof && m_eol == hold_eol,
                    "R8", "stalled output changed", longint'(m_data), longint'(hold_data));
            hold_prev = m_valid && !m_ready;
            hold_data = m_data;
            hold_sof  = m_sof;
            hold_eol  = m_eol;

            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected output pixel", longint'(m_data), -1);
                end else begin
                    int e, ac;
                    bit es, ee, lt;
                    string t;
                    e = exp_q.pop_front(); es = esof_q.pop_front(); ee = eeol_q.pop_front();
                    t = tag_q.pop_front(); ac = acyc_q.pop_front(); lt = lat_q.pop_front();
                    chk(int'(m_data) == e, t, "pixel value", longint'(m_data), e);
                    chk(m_sof == es && m_eol == ee, "R8", "frame flags",
                        {m_sof, m_eol}, {es, ee});
                    if (lt) chk(cyc - ac == 3, "R7", "latency", cyc - ac, 3);
                end
            end

            if (s_valid && s_ready) begin
                int s;
                if (s_sof) begin
                    act_ped = stg_ped; act_gain = stg_gain;
                    act_ph = stg_ph; act_md = stg_md;
                    row = 0; col = 0;
                end
                s = 2 * (row ^ (act_ph >> 1 & 1)) + (col ^ (act_ph & 1));
                exp_q.push_back(model_pix(int'(s_data), act_ped[s], act_gain[s], act_md));
                esof_q.push_back(s_sof); eeol_q.push_back(s_eol);
                tag_q.push_back(tag); acyc_q.push_back(cyc); lat_q.push_back(steady);
                if (s_eol) begin col = 0; row ^= 1; end
                else col ^= 1;
            end

            if (cfg_we) begin
                int a, w;
                a = int'(cfg_addr); w = int'(cfg_wdata);
                if (a < 4) stg_ped[a] = w & MAXV;
                else if (a < 8) stg_gain[a-4] = w;
                else if (a == 8) stg_ph = w & 3;
                else if (a == 9) stg_md = w & 3;
            end
        end
    end

    // Register write (R2 address map), issued at a falling edge.
    task automatic cfg_write(int a, int w);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(w);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_pix(int p, bit sf, bit el);
        s_valid = 1'b1; s_data = PIX_W'(p); s_sof = sf; s_eol = el;
        #1;
        while (!s_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0;
    endtask

    task automatic send_frame(int rows, int cols, bit gaps, int wr_at, int wa, int wd);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++) begin
                int p;
                p = pix_lo + int'($urandom % (pix_hi - pix_lo + 1));
                send_pix(p, r == 0 && c == 0, c == cols - 1);
                if (gaps && ($urandom % 2) == 0) @(negedge clk);
                if (r * cols + c == wr_at) cfg_write(wa, wd);
            end
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_all(int ped, int gain);
        for (int i = 0; i < 4; i++) begin
            cfg_write(i, ped);
            cfg_write(4 + i, gain);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog: got %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(m_valid == 1'b0, "R7", "m_valid after reset", longint'(m_valid), 0);
        chk(s_ready == 1'b1, "R8", "s_ready after reset", longint'(s_ready), 1);
        @(negedge clk);

        // R9 reset values: pedestal 0, gain 1.0 gives a pass-through.
        tag = "R9"; pix_lo = 0; pix_hi = MAXV;
        send_frame(3, 4, 1'b0, -1, 0, 0);
        drain();

        // R2 and R1: distinct per-site settings, phase 0.
        tag = "R2";
        cfg_write(0, 16); cfg_write(1, 32); cfg_write(2, 48); cfg_write(3, 64);
        cfg_write(4, 16'h1000); cfg_write(5, 16'h1800);
        cfg_write(6, 16'h2000); cfg_write(7, 16'h0C00);
        cfg_write(9, 0);
        pix_lo = 100; pix_hi = 2000;
        send_frame(4, 6, 1'b1, -1, 0, 0);
        drain();

        // R1: every mosaic phase.
        tag = "R1";
        for (int ph = 1; ph < 4; ph++) begin
            cfg_write(8, ph);
            send_frame(4, 5, 1'b0, -1, 0, 0);
        end
        drain();

        // R3: below-pedestal pixels clip with folding off.
        tag = "R3"; cfg_write(8, 0);
        set_all(200, 16'h1000); cfg_write(9, 0);
        pix_lo = 0; pix_hi = 400;
        send_frame(4, 4, 1'b0, -1, 0, 0);
        drain();

        // R4: folding on but forced zero.
        tag = "R4"; cfg_write(9, 3);
        send_frame(4, 4, 1'b0, -1, 0, 0);
        drain();

        // R5: folding on, negatives take their magnitude.
        tag = "R5"; cfg_write(9, 1);
        send_frame(4, 4, 1'b0, -1, 0, 0);
        drain();

        // R6: saturation at the top of the range.
        tag = "R6"; cfg_write(9, 0);
        set_all(0, 16'hFFFF);
        pix_lo = 3000; pix_hi = MAXV;
        send_frame(2, 4, 1'b0, -1, 0, 0);
        drain();

        // R6: rounding with gain one half and gain of one LSB.
        set_all(0, 16'h0800);
        pix_lo = 0; pix_hi = MAXV;
        send_frame(3, 4, 1'b0, -1, 0, 0);
        cfg_write(4, 1); cfg_write(5, 16'h0801); cfg_write(6, 16'h17FF); cfg_write(7, 3);
        send_frame(3, 4, 1'b0, -1, 0, 0);
        drain();

        // R8: random output stalls with input gaps.
        tag = "R8"; steady = 1'b0; stall_mode = 1'b1;
        cfg_write(0, 10); cfg_write(1, 300); cfg_write(4, 16'h1400); cfg_write(5, 16'h2800);
        cfg_write(9, 1);
        for (int f = 0; f < 3; f++) send_frame(5, 6, 1'b1, -1, 0, 0);
        stall_mode = 1'b0;
        drain();
        steady = 1'b1;

        // R9: writes made mid-frame wait for the next frame start.
        tag = "R9";
        send_frame(4, 4, 1'b0, 5, 0, 900);
        send_frame(4, 4, 1'b0, 3, 8, 3);
        send_frame(4, 4, 1'b0, 2, 5, 16'h3000);
        send_frame(4, 4, 1'b0, -1, 0, 0);
        drain();

        finish_run();
    end
endmodule